// File: doc/BRIEF.md
# Audio Serial Port Clock Generator

This block derives the bit clock and the word-select clock of a stereo audio serial port from the master clock it runs on. In every mode, a frame holds 64 bit-clock periods. The left channel occupies the low half of the word-select clock and the right channel the high half. A 2-bit speed field and a 3-bit ratio code together set how many master-clock periods make up one frame. In single-speed mode this ranges from 1024 down to 64 in quad-speed mode, which covers frame rates of roughly 4 kHz to 216 kHz.

Some settings need a bit-clock divisor of 3 or 1.5 master-clock periods. To produce these, the block tracks its position in half master-clock periods. Each output is formed from two registered levels, one for the high phase of the master clock and one for the low phase, and the master clock itself selects between them. The mode, speed and ratio inputs are captured only while the power-down input is high. When power-down is released, the outputs start from a low state at the beginning of a left frame. A one-cycle strobe marks each frame start for downstream data shifters. In slave mode the output enable is low and both clocks are held low.

Top module: `ssclk_gen`

## Requirements
- R1: Every word-select period contains exactly 64 bit-clock periods. The word-select clock is low (left) for the first 32 of them and high for the next 32.
- R2: With speed_i = 00 (single speed), ratio_i values 000, 001, 010, 011 and 100 give 256, 384, 512, 768 and 1024 master-clock periods per frame.
- R3: With speed_i = 01 (double speed), the same codes give 128, 192, 256, 384 and 512 master-clock periods per frame.
- R4: With speed_i = 10 (quad speed), the same codes give 64, 96, 128, 192 and 256 periods per frame. Code 000 gives a bit clock that is low while the master clock is high and high while it is low. Code 001 gives a bit clock that is low for one master half-period and high for the next two.
- R5: A divisor of 3 (double code 001, quad code 011) gives a bit clock that is low for three master half-periods and high for three.
- R6: Ratio codes 101, 110 and 111 behave as code 000 of the selected speed. speed_i = 11 behaves as single speed.
- R7: master_i, speed_i and ratio_i are captured only on clock edges where pdn_i is high. Changes made while pdn_i is low have no effect on the outputs.
- R8: After reset the block is in slave mode: clk_oe_o is low and sclk_o, lrck_o and frame_start_o are low.
- R9: In slave mode (master_i captured as 0), clk_oe_o, sclk_o, lrck_o and frame_start_o stay low.
- R10: The word-select clock changes level only at the start of a bit-clock low phase, that is, on a bit-clock falling edge.
- R11: While pdn_i is high, both clocks are low. In the master-clock cycle after the first edge at which pdn_i is sampled low, a left frame starts with the bit clock in its low phase.
- R12: In master mode, frame_start_o is high for exactly the one master-clock cycle in which each frame begins, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mclk | input | 1 | Master clock; both of its phases are used |
| rst_n | input | 1 | Synchronous active-low reset |
| pdn_i | input | 1 | Power-down; configuration is captured while high |
| master_i | input | 1 | 1 = generate clocks, 0 = slave |
| speed_i | input | 2 | 00 single, 01 double, 10 quad, 11 as single |
| ratio_i | input | 3 | Ratio code within the speed mode |
| sclk_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Word-select clock, low = left |
| clk_oe_o | output | 1 | Output enable for both clocks |
| frame_start_o | output | 1 | One-cycle strobe at each frame start |

## Verification
A frame start and the wrap of the bit-clock period fall in the same master-clock cycle. The word-select edge must line up with a bit-clock falling edge in that cycle. A release of power-down then starts a new frame in the very next cycle. Both coincidences are provoked by running every speed and ratio pair for at least two full frames, and by reasserting power-down in the middle of frames. A behavioural model computes the expected level of each half-period by dividing the half-period index by the bit-clock length. Both phases of every master-clock cycle are compared against it.

// File: rtl/ssclk_pkg.sv
// Shared types and the ratio-to-period mapping for the serial clock generator.
package ssclk_pkg;

    // Width of the bit-clock period count, in master half-periods (max 32).
    localparam int PH_W = 6;

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_SPARE  = 2'b11
    } speed_e;

    typedef struct packed {
        logic       master;
        speed_e     speed;
        logic [2:0] code;
    } cfg_t;

    // Half master-clock periods per bit-clock period for a speed/code pair.
    function automatic logic [PH_W-1:0] half_period(speed_e spd, logic [2:0] code);
        logic [PH_W-1:0] base;
        case (code)
            3'd1:    base = PH_W'(3);
            3'd2:    base = PH_W'(4);
            3'd3:    base = PH_W'(6);
            3'd4:    base = PH_W'(8);
            default: base = PH_W'(2);
        endcase
        case (spd)
            SPD_QUAD:   half_period = base;
            SPD_DOUBLE: half_period = base << 1;
            default:    half_period = base << 2;
        endcase
    endfunction

endpackage

// File: rtl/ssclk_cfg_latch.sv
// Configuration holder. Captures mode, speed and ratio only while power-down
// is high; assumes the inputs are static in the master-clock domain.
module ssclk_cfg_latch
    import ssclk_pkg::*;
(
    input  logic            clk_mclk,
    input  logic            rst_n,
    input  logic            pdn_i,
    input  logic            master_i,
    input  logic [1:0]      speed_i,
    input  logic [2:0]      ratio_i,
    output logic            master_q,
    output logic [PH_W-1:0] period_o
);

    cfg_t cfg_q;

    // Capture configuration during power-down, default to slave on reset.
    always_ff @(posedge clk_mclk) begin
        if (!rst_n) begin
            cfg_q <= '{master: 1'b0, speed: SPD_SINGLE, code: 3'd0};
        end else if (pdn_i) begin
            cfg_q <= '{master: master_i, speed: speed_e'(speed_i), code: ratio_i};
        end
    end

    assign master_q = cfg_q.master;
    assign period_o = half_period(cfg_q.speed, cfg_q.code);

endmodule

// File: rtl/ssclk_half_step.sv
// One half master-period step of the position counter: reports the clock
// levels at the given position and computes the following position.
// Assumes period >= 2 and ph < period.
module ssclk_half_step
    import ssclk_pkg::*;
#(
    parameter int FRAME_BITS = 64,
    localparam int BIT_W = $clog2(FRAME_BITS)
) (
    input  logic [PH_W-1:0]  period,
    input  logic [PH_W-1:0]  ph,
    input  logic [BIT_W-1:0] bitn,
    output logic [PH_W-1:0]  ph_nxt,
    output logic [BIT_W-1:0] bit_nxt,
    output logic             sclk_lvl,
    output logic             lrck_lvl
);

    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(FRAME_BITS - 1);
    localparam logic [BIT_W-1:0] RIGHT_BIT = BIT_W'(FRAME_BITS / 2);

    // Levels: low for the first floor(period/2) halves, left for the first half frame.
    always_comb begin
        sclk_lvl = (ph >= (period >> 1));
        lrck_lvl = (bitn >= RIGHT_BIT);
    end

    // Advance by one half-period, wrapping the bit count at the frame end.
    always_comb begin
        if (ph == period - PH_W'(1)) begin
            ph_nxt  = '0;
            bit_nxt = (bitn == LAST_BIT) ? '0 : bitn + BIT_W'(1);
        end else begin
            ph_nxt  = ph + PH_W'(1);
            bit_nxt = bitn;
        end
    end

endmodule

// File: rtl/ssclk_seq.sv
// Frame position sequencer. Holds the position at the start of each master
// cycle and chains two half steps to give both phase levels. Frame starts
// always fall on a rising master edge since a frame spans an even number
// of half-periods.
module ssclk_seq
    import ssclk_pkg::*;
#(
    parameter int FRAME_BITS = 64,
    localparam int BIT_W = $clog2(FRAME_BITS),
    localparam int HALVES = 2
) (
    input  logic            clk_mclk,
    input  logic            rst_n,
    input  logic            pdn_i,
    input  logic [PH_W-1:0] period,
    output logic            run_o,
    output logic            origin_o,
    output logic            sclk_hi,
    output logic            sclk_lo,
    output logic            lrck_hi,
    output logic            lrck_lo
);

    logic [PH_W-1:0]  ph_q;
    logic [BIT_W-1:0] bit_q;
    logic             run_q;

    logic [PH_W-1:0]  ph_c  [0:HALVES];
    logic [BIT_W-1:0] bit_c [0:HALVES];
    logic [HALVES-1:0] s_lvl;
    logic [HALVES-1:0] l_lvl;

    assign ph_c[0]  = ph_q;
    assign bit_c[0] = bit_q;

    // Chain of half steps, one per master-clock phase.
    for (genvar k = 0; k < HALVES; k++) begin : g_half
        ssclk_half_step #(.FRAME_BITS(FRAME_BITS)) step_i (
            .period   (period),
            .ph       (ph_c[k]),
            .bitn     (bit_c[k]),
            .ph_nxt   (ph_c[k+1]),
            .bit_nxt  (bit_c[k+1]),
            .sclk_lvl (s_lvl[k]),
            .lrck_lvl (l_lvl[k])
        );
    end

    // Hold position at frame origin during power-down, advance one cycle otherwise.
    always_ff @(posedge clk_mclk) begin
        if (!rst_n || pdn_i) begin
            ph_q  <= '0;
            bit_q <= '0;
            run_q <= 1'b0;
        end else begin
            run_q <= 1'b1;
            if (run_q) begin
                ph_q  <= ph_c[HALVES];
                bit_q <= bit_c[HALVES];
            end
        end
    end

    assign run_o    = run_q;
    assign origin_o = run_q && (ph_q == '0) && (bit_q == '0);
    assign sclk_hi  = run_q && s_lvl[0];
    assign sclk_lo  = run_q && s_lvl[1];
    assign lrck_hi  = run_q && l_lvl[0];
    assign lrck_lo  = run_q && l_lvl[1];

endmodule

// File: rtl/ssclk_gen.sv
// Audio serial port clock generator top. Selects the per-phase levels with
// the master clock itself, so that odd half-period divisors are exact.
// Assumes the configuration inputs change only while power-down is high.
module ssclk_gen
    import ssclk_pkg::*;
#(
    parameter int FRAME_BITS = 64
) (
    input  logic       clk_mclk,
    input  logic       rst_n,
    input  logic       pdn_i,
    input  logic       master_i,
    input  logic [1:0] speed_i,
    input  logic [2:0] ratio_i,
    output logic       sclk_o,
    output logic       lrck_o,
    output logic       clk_oe_o,
    output logic       frame_start_o
);

    logic            master_q;
    logic [PH_W-1:0] period_w;
    logic            run_w;
    logic            origin_w;
    logic            sclk_hi, sclk_lo, lrck_hi, lrck_lo;
    logic            active;

    ssclk_cfg_latch cfg_i (
        .clk_mclk (clk_mclk),
        .rst_n    (rst_n),
        .pdn_i    (pdn_i),
        .master_i (master_i),
        .speed_i  (speed_i),
        .ratio_i  (ratio_i),
        .master_q (master_q),
        .period_o (period_w)
    );

    ssclk_seq #(.FRAME_BITS(FRAME_BITS)) seq_i (
        .clk_mclk (clk_mclk),
        .rst_n    (rst_n),
        .pdn_i    (pdn_i),
        .period   (period_w),
        .run_o    (run_w),
        .origin_o (origin_w),
        .sclk_hi  (sclk_hi),
        .sclk_lo  (sclk_lo),
        .lrck_hi  (lrck_hi),
        .lrck_lo  (lrck_lo)
    );

    // Output stage: phase select by the master clock, gated by master mode.
    always_comb begin
        active        = master_q && run_w;
        sclk_o        = active && (clk_mclk ? sclk_hi : sclk_lo);
        lrck_o        = active && (clk_mclk ? lrck_hi : lrck_lo);
        clk_oe_o      = master_q;
        frame_start_o = active && origin_w;
    end

endmodule

// File: rtl/ssclk_gen_chk.sv
// Protocol checker for the serial clock generator, bound to the top.
module ssclk_gen_chk (
    input logic       clk_mclk,
    input logic       rst_n,
    input logic       pdn_i,
    input logic       clk_oe_o,
    input logic       lrck_o,
    input logic       frame_start_o,
    input logic [5:0] period_w
);

    AST_RESET_SLAVE: assert property (@(posedge clk_mclk)
        !rst_n |=> (!clk_oe_o && !frame_start_o)); // R8

    AST_SLAVE_QUIET: assert property (@(posedge clk_mclk) disable iff (!rst_n)
        !clk_oe_o |-> (!lrck_o && !frame_start_o)); // R9

    AST_CFG_HELD: assert property (@(posedge clk_mclk) disable iff (!rst_n)
        (rst_n && !pdn_i) |=> $stable(period_w)); // R7

    AST_STROBE_SINGLE: assert property (@(posedge clk_mclk) disable iff (!rst_n)
        frame_start_o |=> !frame_start_o); // R12

    AST_PDN_NO_STROBE: assert property (@(posedge clk_mclk) disable iff (!rst_n)
        (rst_n && pdn_i) |=> !frame_start_o); // R11

    AST_RELEASE_FRAME: assert property (@(posedge clk_mclk) disable iff (!rst_n)
        (rst_n && $fell(pdn_i)) |=> (frame_start_o == clk_oe_o)); // R11

endmodule

bind ssclk_gen ssclk_gen_chk chk_i (
    .clk_mclk      (clk_mclk),
    .rst_n         (rst_n),
    .pdn_i         (pdn_i),
    .clk_oe_o      (clk_oe_o),
    .lrck_o        (lrck_o),
    .frame_start_o (frame_start_o),
    .period_w      (period_w)
);

// File: tb/ssclk_gen_tb_top.sv
`timescale 1ns/1ps
module ssclk_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pdn = 1'b1;
    logic       master = 1'b0;
    logic [1:0] speed = 2'b00;
    logic [2:0] ratio = 3'b000;
    logic       sclk, lrck, oe, fstart;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // model state
    bit m_master = 0;
    int m_speed  = 0;
    int m_code   = 0;
    bit m_run    = 0;
    int h        = 0;

    always #4 clk = ~clk;

    ssclk_gen dut_i (
        .clk_mclk      (clk),
        .rst_n         (rst_n),
        .pdn_i         (pdn),
        .master_i      (master),
        .speed_i       (speed),
        .ratio_i       (ratio),
        .sclk_o        (sclk),
        .lrck_o        (lrck),
        .clk_oe_o      (oe),
        .frame_start_o (fstart)
    );

    // Master-clock periods per frame from the ratio tables (R2, R3, R4, R6).
    function automatic int frame_len(int spd, int code);
        int c;
        int base;
        c = (code > 4) ? 0 : code;
        case (c)
            0: base = 256;
            1: base = 384;
            2: base = 512;
            3: base = 768;
            default: base = 1024;
        endcase
        if (spd == 1) return base / 2;
        if (spd == 2) return base / 4;
        return base;
    endfunction

    function automatic string sclk_req();
        if (!m_master) return "R9";
        if (m_code > 4 || m_speed == 3) return "R6";
        if (m_speed == 0) return "R2";
        if (m_speed == 1) return (m_code == 1) ? "R5" : "R3";
        return (m_code == 3) ? "R5" : "R4";
    endfunction

    task automatic chk(string req, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
        end
    endtask

    // Behavioural model: half-period index h within the frame.
    always @(posedge clk) begin
        int p;
        int hh;
        bit act;
        if (!rst_n) begin
            m_master = 0; m_speed = 0; m_code = 0; m_run = 0; h = 0;
        end else if (pdn) begin
            m_master = master; m_speed = speed; m_code = ratio; m_run = 0; h = 0;
        end else begin
            if (m_run) h = (h + 2) % (2 * frame_len(m_speed, m_code));
            m_run = 1;
        end
        p   = frame_len(m_speed, m_code) / 32;
        act = m_master && m_run;
        #2;
        hh = h;
        chk(sclk_req(), sclk, act && ((hh % p) >= (p / 2)));
        chk("R1 R10 lrck", lrck, act && ((hh / p) >= 32));
        chk("R8 R9 oe", oe, m_master);
        chk("R12 frame_start", fstart, act && (hh == 0));
        #4;
        hh = h + 1;
        chk(sclk_req(), sclk, act && ((hh % p) >= (p / 2)));
        chk("R1 R10 lrck", lrck, act && ((hh / p) >= 32));
    end

    task automatic run_cfg(bit m, int sp, int cd, int cycles);
        @(negedge clk); #1;
        pdn = 1'b1; master = m; speed = 2'(sp); ratio = 3'(cd);
        @(negedge clk); #1;
        pdn = 1'b0;
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);     // R8: reset state checked each cycle
        @(negedge clk); #1;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R2 R3 R4 R5: all fifteen ratio pairs, two frames each
        for (int sp = 0; sp < 3; sp++) begin
            for (int cd = 0; cd < 5; cd++) begin
                run_cfg(1'b1, sp, cd, 2 * frame_len(sp, cd) + 7);
            end
        end
        // R6: reserved codes and spare speed value
        for (int cd = 5; cd < 8; cd++) run_cfg(1'b1, 2, cd, 140);
        run_cfg(1'b1, 3, 1, 800);
        // R11: power-down reasserted mid-frame, restart at left frame
        run_cfg(1'b1, 1, 1, 150);
        run_cfg(1'b1, 2, 1, 100);
        // R7: changes while running are ignored
        run_cfg(1'b1, 2, 0, 30);
        @(negedge clk); #1;
        master = 1'b0; speed = 2'b00; ratio = 3'd4;
        repeat (200) @(negedge clk);
        // R9: slave mode keeps outputs quiet
        run_cfg(1'b0, 2, 0, 200);
        run_cfg(1'b1, 2, 1, 100);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule